// File: doc/BRIEF.md
# Vertical Line Window Filter

This block sits between an image sensor's parallel pixel port and the capture logic. It passes on only the rows that belong to the desired image window. The sensor trims each row horizontally on its own, but it has no notion of how many rows are wanted. When its integration timing is driven from outside, it keeps strobing line-valid for rows past the window and even past the physical array, with frame-valid held high throughout. The filter counts rows inside each frame and drops every row whose index is at or above the limit.

Every row's fate is settled on its first pixel. A row is forwarded when frame-valid is high at that moment and the current row index is below the limit. In externally-timed mode the limit is the smaller of the programmed height and the array size. In self-timed mode it is the array size alone. Forwarded pixels come out two clock cycles after they are sampled. They carry start-of-line and end-of-line markers, and the final row of the window is also marked with an end-of-window pulse.

Top module: `line_window_filter`

## Requirements
- R1: While reset is asserted and on the first cycles after it, pix_vld, sol, eol and eow are all low.
- R2: A pixel sampled with lval_in high on an accepted row appears unchanged on pix_out with pix_vld high exactly two clock edges later, in sampling order.
- R3: A row whose first pixel is sampled while fval_in is low produces no output at all.
- R4: The row counter restarts at zero on each rising edge of fval_in, so the first row of every frame is row 0 and is accepted whenever the limit is non-zero.
- R5: With slave_mode = 1, rows with index at or above win_rows are dropped entirely; win_rows = 0 drops every row.
- R6: In both modes, rows with index at or above the array size ROWS are dropped, whatever win_rows holds.
- R7: With slave_mode = 0, win_rows has no effect; exactly rows 0 to ROWS-1 of a frame are forwarded.
- R8: sol is high only with the first forwarded pixel of a row and eol only with its last; for a one-pixel row both are high on the same pixel.
- R9: eow is a single-cycle pulse, high together with eol on the last pixel of row (limit-1); a frame whose limit is zero produces no eow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_in | input | DW | Pixel data from the sensor |
| lval_in | input | 1 | Line-valid from the sensor |
| fval_in | input | 1 | Frame-valid from the sensor |
| win_rows | input | LW | Programmed window height in rows (externally-timed mode) |
| slave_mode | input | 1 | 1: externally-timed mode, 0: self-timed mode |
| pix_out | output | DW | Forwarded pixel data |
| pix_vld | output | 1 | pix_out holds an accepted pixel |
| sol | output | 1 | First pixel of a forwarded row |
| eol | output | 1 | Last pixel of a forwarded row |
| eow | output | 1 | Last pixel of the last row of the window |

## Verification
A wrong row count shows up on the first row after a frame start. A row is then forwarded that should be dropped, or one goes missing, within two cycles of its first pixel. Either way the ordered expected-pixel list falls out of step at once. A wrong acceptance flag or marker shows on the first pixel of the affected row. A late or missing end-of-window pulse is seen on the eol pixel of row limit-1. A stray pulse is seen in the cycle where it occurs.

// File: rtl/line_window_filter.sv
module line_window_filter #(
  parameter int DW   = 10,
  parameter int LW   = 10,
  parameter int ROWS = 480
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] pix_in,
  input  logic          lval_in,
  input  logic          fval_in,
  input  logic [LW-1:0] win_rows,
  input  logic          slave_mode,
  output logic [DW-1:0] pix_out,
  output logic          pix_vld,
  output logic          sol,
  output logic          eol,
  output logic          eow
);
  localparam logic [LW-1:0] CAP = LW'(ROWS);

  logic [DW-1:0] r1_pix;
  logic          r1_lv, r1_first, fv_q, line_ok, line_fv;
  logic [LW-1:0] cnt;

  wire          frame_start = fval_in & ~fv_q;
  wire [LW-1:0] cnt_now     = frame_start ? '0 : cnt;
  wire [LW-1:0] limit       = (slave_mode && win_rows < CAP) ? win_rows : CAP;
  wire          line_start  = lval_in & ~r1_lv;
  wire          line_end    = r1_lv & ~lval_in;
  wire          last_line   = line_ok && (cnt + 1'b1 == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r1_pix   <= '0;
      r1_lv    <= 1'b0;
      r1_first <= 1'b0;
      fv_q     <= 1'b0;
      line_ok  <= 1'b0;
      line_fv  <= 1'b0;
      cnt      <= '0;
    end else begin
      r1_pix   <= pix_in;
      r1_lv    <= lval_in;
      r1_first <= line_start;
      fv_q     <= fval_in;
      if (line_start) begin
        line_ok <= fval_in && (cnt_now < limit);
        line_fv <= fval_in;
      end
      if (frame_start)
        cnt <= '0;
      else if (line_end && line_fv && cnt < CAP)
        cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_out <= '0;
      pix_vld <= 1'b0;
      sol     <= 1'b0;
      eol     <= 1'b0;
      eow     <= 1'b0;
    end else begin
      pix_out <= r1_pix;
      pix_vld <= r1_lv & line_ok;
      sol     <= r1_lv & r1_first & line_ok;
      eol     <= line_end & line_ok;
      eow     <= line_end & last_line;
    end
  end

  assert_sol_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sol || eol) |-> pix_vld);

  assert_row_begins_sol_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_vld) |-> sol);

  assert_eow_on_eol_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eow |-> (eol && pix_vld));

  assert_eow_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eow |=> !eow);

  assert_under_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld && !eol) |-> (cnt < CAP));
endmodule

// File: tb/test_line_window_filter.sv
module test_line_window_filter;
  localparam int DW = 10, LW = 4, ROWS = 6, NL = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DW-1:0] pix_in = '0;
  logic lval_in = 1'b0, fval_in = 1'b0, slave_mode = 1'b0;
  logic [LW-1:0] win_rows = '0;
  logic [DW-1:0] pix_out;
  logic pix_vld, sol, eol, eow;

  line_window_filter #(.DW(DW), .LW(LW), .ROWS(ROWS)) i_line_window_filter (
    .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .lval_in(lval_in),
    .fval_in(fval_in), .win_rows(win_rows), .slave_mode(slave_mode),
    .pix_out(pix_out), .pix_vld(pix_vld), .sol(sol), .eol(eol), .eow(eow));

  always #5ns clk = ~clk;

  int checks = 0, errors = 0, eow_seen = 0, eow_exp = 0;
  bit mon_on = 1'b0, done = 1'b0;
  string cur_tag = "R2";
  logic [DW+3:0] expq[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (mon_on) begin
    if (eow) eow_seen++;
    if (pix_vld) begin
      if (expq.size() == 0)
        chk(1'b0, cur_tag, "pixel on dropped row", int'(pix_out), -1);
      else begin
        logic [DW+3:0] e;
        e = expq.pop_front();
        chk(pix_out == e[DW-1:0], e[DW+3] ? "R4" : "R2", "pixel value",
            int'(pix_out), int'(e[DW-1:0]));
        chk(sol == e[DW+1], "R8", "sol marker", int'(sol), int'(e[DW+1]));
        chk(eol == e[DW], "R8", "eol marker", int'(eol), int'(e[DW]));
        chk(eow == e[DW+2], "R9", "eow pulse", int'(eow), int'(e[DW+2]));
      end
    end else
      chk(!sol && !eol && !eow, "R8", "marker without pixel",
          int'({sol, eol, eow}), 0);
  end

  task automatic drive(input logic fv, input logic lv, input logic [DW-1:0] px);
    @(negedge clk);
    fval_in = fv; lval_in = lv; pix_in = px;
  endtask

  task automatic frame(input logic sl, input int win, input int fidx);
    int lim;
    lim = sl ? ((win < ROWS) ? win : ROWS) : ROWS;
    slave_mode = sl;
    win_rows = LW'(win);
    drive(1'b1, 1'b0, '0);
    drive(1'b1, 1'b0, '0);
    for (int k = 0; k < NL; k++) begin
      int len;
      len = 1 + (k % 4);
      if (k >= ROWS) cur_tag = "R6";
      else if (sl) cur_tag = "R5";
      else cur_tag = "R7";
      for (int i = 0; i < len; i++) begin
        logic [DW-1:0] px;
        px = DW'(fidx * 37 + k * 11 + i * 3 + 5);
        if (k < lim)
          expq.push_back({k == 0, (k == lim - 1) && (i == len - 1),
                          i == 0, i == len - 1, px});
        drive(1'b1, 1'b1, px);
      end
      drive(1'b1, 1'b0, '0);
      drive(1'b1, 1'b0, '0);
    end
    if (lim > 0) eow_exp++;
    drive(1'b0, 1'b0, '0);
    drive(1'b0, 1'b0, '0);
    cur_tag = "R3";
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b1, DW'(fidx + i + 1));
    drive(1'b0, 1'b0, '0);
    drive(1'b0, 1'b0, '0);
    drive(1'b0, 1'b0, '0);
  endtask

  initial begin
    int fidx;
    fidx = 0;
    repeat (3) @(negedge clk);
    chk(!pix_vld && !sol && !eol && !eow, "R1", "outputs in reset",
        int'({pix_vld, sol, eol, eow}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pix_vld && !sol && !eol && !eow, "R1", "outputs after reset",
        int'({pix_vld, sol, eol, eow}), 0);
    mon_on = 1'b1;
    for (int sl = 0; sl < 2; sl++)
      for (int w = 0; w < 10; w++) begin
        frame(sl[0], w, fidx);
        fidx++;
      end
    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R2", "forwarded pixel missing", expq.size(), 0);
    chk(eow_seen == eow_exp, "R9", "eow pulse count", eow_seen, eow_exp);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500us;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule